// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers the eight interrupt causes of a serial-bus controller into one place. Five causes are FIFO threshold levels (almost-empty or almost-full) that the block passes straight through. Three are events (a command response has arrived, an in-band interrupt has been queued, an address assignment is waiting for software) that the block latches, because the condition behind them lasts longer than the pulse that reports it.

Software sees three registers through a plain strobe interface: a mask word, a raw source word, and a pending word. The pending word is the source word ANDed with the mask. A single registered interrupt line is raised whenever any pending bit is set. The latched event bits do not clear on a simple write. Each is released only when the FIFO behind it has reached the state that shows the event has been handled.

Top module: `irq_status_ctrl`

## Requirements
- R1: Source word bit order, LSB first, is: 0 command almost-empty, 1 response almost-full, 2 output-data almost-empty, 3 input-data almost-full, 4 interrupt-queue almost-full, 5 response pending, 6 in-band interrupt pending, 7 address pending. `thr_lvl_i[4:0]` feeds bits 4..0 and `evt_i[2:0]` feeds bits 7..5.
- R2: The mask register is at address 0x0 and resets to 0. A write stores `reg_wdata_i[7:0]`, and a read returns it in bits 7..0.
- R3: A read of address 0x2 returns the source word with no mask applied. Writes to 0x2 have no effect.
- R4: A read of address 0x1 returns the source word ANDed with the mask.
- R5: Writing 1 to bit 5 at address 0x1 clears response pending only when `rsp_fifo_empty_i` is 1. Otherwise the bit stays set.
- R6: Writing 1 to bit 6 at address 0x1 clears in-band interrupt pending only when `ibq_fifo_empty_i` is 1.
- R7: Address pending clears on its own in any cycle in which `out_fifo_empty_i` is 0. Writing 1 to bit 7 has no effect on it.
- R8: Bits 7..5 are sticky. A one-cycle pulse on their event input sets them, and a set in the same cycle as a clear leaves the bit set.
- R9: Bits 4..0 follow their level inputs in the same cycle and are not latched. Writes to address 0x1 do not change them.
- R10: `irq_o` is a register holding the OR of the pending word as it stood one cycle earlier.
- R11: Read data is registered. It is loaded at the clock edge where `reg_rd_i` is high and holds until the next read. An unmapped address reads as 0.
- R12: After reset, the source, pending, read data and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_lvl_i | input | 5 | FIFO threshold levels, source bits 4..0 |
| evt_i | input | 3 | Event pulses: 0 response, 1 in-band interrupt, 2 address request |
| rsp_fifo_empty_i | input | 1 | Response FIFO is empty |
| ibq_fifo_empty_i | input | 1 | Interrupt queue FIFO is empty |
| out_fifo_empty_i | input | 1 | Output-data FIFO is empty |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is a latched event bit that receives its set and its clear on the same clock edge. To be visible, the bit must then be read before the following clear edge lands. For the address bit, the bench raises the event pulse while the output FIFO is already non-empty. It issues the read on the very next cycle, so the registered read data captures the bit at the one edge where it holds 1, and a second read shows it cleared. For the response bit, the bench raises the event pulse and the write-one-to-clear in the same cycle with the FIFO empty, and checks that the bit survives.

// File: rtl/irq_status_pkg.sv
// Package: shared constants and types for the interrupt status controller.
// Assumes: five level sources occupy the low bits, three event sources the high bits.
package irq_status_pkg;

    localparam int NUM_LVL = 5;
    localparam int NUM_EVT = 3;
    localparam int NUM_SRC = NUM_LVL + NUM_EVT;

    // Bit position of each source in the source and pending words.
    typedef enum logic [2:0] {
        SRC_CMD_LOW  = 3'd0,
        SRC_RSP_HIGH = 3'd1,
        SRC_OUT_LOW  = 3'd2,
        SRC_IN_HIGH  = 3'd3,
        SRC_IBQ_HIGH = 3'd4,
        SRC_RSP_EVT  = 3'd5,
        SRC_IBI_EVT  = 3'd6,
        SRC_ADDR_EVT = 3'd7
    } src_idx_e;

    // How a sticky event bit is released.
    typedef enum logic [0:0] {
        CLR_W1C_WHEN_EMPTY = 1'b0,
        CLR_AUTO_NONEMPTY  = 1'b1
    } clr_rule_e;

    // Release rule for event slot k (0 = response, 1 = in-band, 2 = address).
    function automatic clr_rule_e evt_clr_rule(input int k);
        return (k == 2) ? CLR_AUTO_NONEMPTY : CLR_W1C_WHEN_EMPTY;
    endfunction

endpackage

// File: rtl/irq_event_latch.sv
// Module: one sticky event bit with a FIFO-gated release.
// Assumes: evt_i is a single-cycle pulse. A set and a clear in the same
// cycle leave the bit set. RULE selects write-one-to-clear gated by an empty
// FIFO, or an automatic release while the FIFO holds data.
module irq_event_latch
    import irq_status_pkg::*;
#(
    parameter clr_rule_e RULE = CLR_W1C_WHEN_EMPTY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic w1c_i,
    input  logic fifo_empty_i,
    output logic flag_o
);

    logic clr_w;

    generate
        if (RULE == CLR_W1C_WHEN_EMPTY) begin : g_w1c
            // Release needs a software write and a drained FIFO.
            assign clr_w = w1c_i & fifo_empty_i;
        end else begin : g_auto
            logic unused_w1c;
            assign unused_w1c = w1c_i;
            // Release as soon as the FIFO holds data.
            assign clr_w = ~fifo_empty_i;
        end
    endgenerate

    // Hold the flag: the set has priority, then the release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (evt_i)
            flag_o <= 1'b1;
        else if (clr_w)
            flag_o <= 1'b0;
    end

endmodule

// File: rtl/irq_reg_if.sv
// Module: register decode for the mask, pending and source words.
// Assumes: one strobe per access. Read data is loaded on the read strobe and
// held until the next one. Writes to the pending word are returned as
// per-bit write-one-to-clear requests.
module irq_reg_if
    import irq_status_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int MASK_ADDR = 0,
    parameter int PEND_ADDR = 1,
    parameter int SRC_ADDR  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               rd_i,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] w1c_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    logic [DATA_W-1:0] rd_mux;
    logic              hit_mask;
    logic              hit_pend;
    logic              hit_src;
    logic [PAD_W-1:0]  unused_wdata_hi;

    assign unused_wdata_hi = wdata_i[DATA_W-1:NUM_SRC];

    // Address decode.
    assign hit_mask = (addr_i == ADDR_W'(MASK_ADDR));
    assign hit_pend = (addr_i == ADDR_W'(PEND_ADDR));
    assign hit_src  = (addr_i == ADDR_W'(SRC_ADDR));

    // Mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (wr_i && hit_mask)
            mask_o <= wdata_i[NUM_SRC-1:0];
    end

    // Clear requests from a write to the pending word.
    always_comb begin
        w1c_o = '0;
        if (wr_i && hit_pend)
            w1c_o = wdata_i[NUM_SRC-1:0];
    end

    // Read selection, zero-extended; unmapped addresses give 0.
    always_comb begin
        rd_mux = '0;
        if (hit_mask)
            rd_mux = {{PAD_W{1'b0}}, mask_o};
        else if (hit_pend)
            rd_mux = {{PAD_W{1'b0}}, pend_i};
        else if (hit_src)
            rd_mux = {{PAD_W{1'b0}}, src_i};
    end

    // Registered read data, loaded on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= rd_mux;
    end

endmodule

// File: rtl/irq_line_gen.sv
// Module: registered interrupt line from the pending word.
// Assumes: pend_i is already masked; the line lags it by one cycle.
module irq_line_gen
    import irq_status_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               irq_o
);

    // OR-reduce the pending word into the line register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= |pend_i;
    end

endmodule

// File: rtl/irq_status_ctrl.sv
// Module: top of the masked interrupt status controller.
// Assumes: threshold inputs are levels and event inputs are one-cycle pulses.
// FIFO flags come from the FIFOs themselves. Bits 4..0 of the source word
// are the levels and bits 7..5 are the sticky event bits.
module irq_status_ctrl
    import irq_status_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int MASK_ADDR = 0,
    parameter int PEND_ADDR = 1,
    parameter int SRC_ADDR  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] thr_lvl_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               rsp_fifo_empty_i,
    input  logic               ibq_fifo_empty_i,
    input  logic               out_fifo_empty_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    input  logic               reg_rd_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] src_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] w1c_w;
    logic [NUM_EVT-1:0] sticky_w;
    logic [NUM_EVT-1:0] evt_empty_w;
    logic [NUM_LVL-1:0] unused_w1c_lvl;

    // Level bits ignore clear requests.
    assign unused_w1c_lvl = w1c_w[NUM_LVL-1:0];

    // FIFO flag that governs each event slot.
    assign evt_empty_w = {out_fifo_empty_i, ibq_fifo_empty_i, rsp_fifo_empty_i};

    // One sticky cell per event source, with its release rule from the package.
    generate
        for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
            irq_event_latch #(
                .RULE(evt_clr_rule(k))
            ) u_latch (
                .clk          (clk),
                .rst_n        (rst_n),
                .evt_i        (evt_i[k]),
                .w1c_i        (w1c_w[NUM_LVL+k]),
                .fifo_empty_i (evt_empty_w[k]),
                .flag_o       (sticky_w[k])
            );
        end
    endgenerate

    // Raw and masked words.
    assign src_w  = {sticky_w, thr_lvl_i};
    assign pend_w = src_w & mask_w;

    irq_reg_if #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .MASK_ADDR (MASK_ADDR),
        .PEND_ADDR (PEND_ADDR),
        .SRC_ADDR  (SRC_ADDR)
    ) u_reg_if (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .rd_i    (reg_rd_i),
        .src_i   (src_w),
        .pend_i  (pend_w),
        .mask_o  (mask_w),
        .w1c_o   (w1c_w),
        .rdata_o (reg_rdata_o)
    );

    irq_line_gen u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_w),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/irq_status_chk.sv
// Module: property checker for irq_status_ctrl, attached by bind.
// Assumes: it observes the internal source and mask words and the top-level ports.
module irq_status_chk
    import irq_status_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int PEND_ADDR = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_i,
    input logic               rsp_fifo_empty_i,
    input logic               ibq_fifo_empty_i,
    input logic               out_fifo_empty_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic               reg_rd_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] src_w,
    input logic [NUM_SRC-1:0] mask_w
);

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_w & mask_w)) |=> irq_o); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src_w & mask_w)) |=> !irq_o); // R10
    AST_PEND_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_W'(PEND_ADDR))
        |=> reg_rdata_o[NUM_SRC-1:0] == $past(src_w & mask_w)); // R4
    AST_RSP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[0] |=> src_w[SRC_RSP_EVT]); // R8
    AST_IBI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[1] |=> src_w[SRC_IBI_EVT]); // R8
    AST_ADDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[2] |=> src_w[SRC_ADDR_EVT]); // R8
    AST_RSP_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_w[SRC_RSP_EVT] && !evt_i[0]) |=> !src_w[SRC_RSP_EVT]); // R8
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_w[SRC_RSP_EVT] && !rsp_fifo_empty_i) |=> src_w[SRC_RSP_EVT]); // R5
    AST_IBI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_w[SRC_IBI_EVT] && !ibq_fifo_empty_i) |=> src_w[SRC_IBI_EVT]); // R6
    AST_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_w[SRC_ADDR_EVT] && !out_fifo_empty_i && !evt_i[2])
        |=> !src_w[SRC_ADDR_EVT]); // R7
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_w[SRC_ADDR_EVT] && out_fifo_empty_i) |=> src_w[SRC_ADDR_EVT]); // R7

endmodule

bind irq_status_ctrl irq_status_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .PEND_ADDR (PEND_ADDR)
) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .evt_i            (evt_i),
    .rsp_fifo_empty_i (rsp_fifo_empty_i),
    .ibq_fifo_empty_i (ibq_fifo_empty_i),
    .out_fifo_empty_i (out_fifo_empty_i),
    .reg_addr_i       (reg_addr_i),
    .reg_rd_i         (reg_rd_i),
    .reg_rdata_o      (reg_rdata_o),
    .irq_o            (irq_o),
    .src_w            (src_w),
    .mask_w           (mask_w)
);

// File: tb/irq_status_ctrl_tb_top.sv
// Directed bench for irq_status_ctrl: one task per scenario, each checking its own results.
module irq_status_ctrl_tb_top;

    localparam logic [3:0] A_MASK = 4'h0;
    localparam logic [3:0] A_PEND = 4'h1;
    localparam logic [3:0] A_SRC  = 4'h2;
    localparam logic [3:0] A_NONE = 4'h9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  thr_lvl = '0;
    logic [2:0]  evt = '0;
    logic        rsp_empty = 1'b1;
    logic        ibq_empty = 1'b1;
    logic        out_empty = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_status_ctrl dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .thr_lvl_i        (thr_lvl),
        .evt_i            (evt),
        .rsp_fifo_empty_i (rsp_empty),
        .ibq_fifo_empty_i (ibq_empty),
        .out_fifo_empty_i (out_empty),
        .reg_addr_i       (addr),
        .reg_wr_i         (wr),
        .reg_wdata_i      (wdata),
        .reg_rd_i         (rd),
        .reg_rdata_o      (rdata),
        .irq_o            (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic pulse_evt(input int k);
        @(negedge clk);
        evt[k] = 1'b1;
        @(negedge clk);
        evt[k] = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R12 rdata after reset", rdata, 32'h0);
        check("R12 irq after reset", {31'h0, irq}, 32'h0);
        read_reg(A_MASK, v); check("R2 mask reset", v, 32'h0);
        read_reg(A_SRC, v);  check("R12 source reset", v, 32'h0);
        read_reg(A_PEND, v); check("R12 pending reset", v, 32'h0);
    endtask

    task automatic t_levels;
        logic [31:0] v;
        @(negedge clk); thr_lvl = 5'b10101;
        read_reg(A_SRC, v);  check("R1 R3 R9 levels in source", v, 32'h15);
        read_reg(A_PEND, v); check("R4 pending masked off", v, 32'h0);
        check("R10 irq low while masked", {31'h0, irq}, 32'h0);
        write_reg(A_MASK, 32'hFFFF_FFFF);
        read_reg(A_MASK, v); check("R2 mask readback", v, 32'hFF);
        read_reg(A_PEND, v); check("R4 pending with full mask", v, 32'h15);
        check("R10 irq high", {31'h0, irq}, 32'h1);
        write_reg(A_PEND, 32'h1F);
        write_reg(A_SRC, 32'hFF);
        read_reg(A_SRC, v);  check("R9 R3 writes ignored by level bits", v, 32'h15);
        @(negedge clk); thr_lvl = 5'b00000;
        check("R10 irq still high before edge", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R10 irq low one cycle later", {31'h0, irq}, 32'h0);
        @(negedge clk); thr_lvl = 5'b01000;
        check("R10 irq waits one edge", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R10 irq rises one cycle later", {31'h0, irq}, 32'h1);
        read_reg(A_SRC, v);  check("R1 R9 input-data bit 3", v, 32'h08);
        @(negedge clk); thr_lvl = 5'b00000;
    endtask

    task automatic t_rsp;
        logic [31:0] v;
        @(negedge clk); rsp_empty = 1'b0;
        pulse_evt(0);
        read_reg(A_SRC, v);  check("R1 R8 response bit 5 set", v, 32'h20);
        write_reg(A_PEND, 32'h20);
        read_reg(A_SRC, v);  check("R5 clear blocked by data in FIFO", v, 32'h20);
        @(negedge clk); rsp_empty = 1'b1;
        read_reg(A_SRC, v);  check("R8 sticky without write", v, 32'h20);
        write_reg(A_PEND, 32'h20);
        read_reg(A_SRC, v);  check("R5 clear with FIFO empty", v, 32'h0);
    endtask

    task automatic t_ibi;
        logic [31:0] v;
        @(negedge clk); ibq_empty = 1'b0;
        pulse_evt(1);
        read_reg(A_SRC, v);  check("R1 R8 in-band bit 6 set", v, 32'h40);
        write_reg(A_PEND, 32'h40);
        read_reg(A_SRC, v);  check("R6 clear blocked by queued entry", v, 32'h40);
        @(negedge clk); ibq_empty = 1'b1;
        write_reg(A_PEND, 32'h40);
        read_reg(A_SRC, v);  check("R6 clear with queue empty", v, 32'h0);
    endtask

    task automatic t_addr;
        logic [31:0] v;
        pulse_evt(2);
        read_reg(A_SRC, v);  check("R1 R8 address bit 7 set", v, 32'h80);
        write_reg(A_PEND, 32'h80);
        read_reg(A_SRC, v);  check("R7 write has no effect", v, 32'h80);
        @(negedge clk); out_empty = 1'b0;
        @(negedge clk);
        read_reg(A_SRC, v);  check("R7 auto clear on non-empty", v, 32'h0);
        @(negedge clk); out_empty = 1'b1;
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        @(negedge clk); out_empty = 1'b0; evt[2] = 1'b1;
        @(negedge clk); evt[2] = 1'b0; addr = A_SRC; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
        check("R8 set beats auto clear", v, 32'h80);
        read_reg(A_SRC, v);  check("R7 cleared the cycle after", v, 32'h0);
        @(negedge clk); out_empty = 1'b1;
        @(negedge clk); evt[0] = 1'b1; addr = A_PEND; wdata = 32'h20; wr = 1'b1;
        @(negedge clk); evt[0] = 1'b0; wr = 1'b0;
        read_reg(A_SRC, v);  check("R8 set beats write-one-to-clear", v, 32'h20);
        write_reg(A_PEND, 32'h20);
        read_reg(A_SRC, v);  check("R5 cleared afterwards", v, 32'h0);
    endtask

    task automatic t_mask_sel;
        logic [31:0] v;
        write_reg(A_MASK, 32'h20);
        pulse_evt(1);
        read_reg(A_PEND, v); check("R4 unmasked source hidden", v, 32'h0);
        read_reg(A_SRC, v);  check("R3 raw source shows bit 6", v, 32'h40);
        check("R10 irq low with bit masked", {31'h0, irq}, 32'h0);
        pulse_evt(0);
        read_reg(A_PEND, v); check("R4 only masked-in bit", v, 32'h20);
        check("R10 irq high", {31'h0, irq}, 32'h1);
        write_reg(A_MASK, 32'h0);
        @(negedge clk);
        check("R2 R10 mask off drops irq", {31'h0, irq}, 32'h0);
        read_reg(A_NONE, v); check("R11 unmapped reads zero", v, 32'h0);
        @(negedge clk); @(negedge clk);
        check("R11 read data holds", rdata, 32'h0);
        read_reg(A_SRC, v);
        @(negedge clk); @(negedge clk);
        check("R11 held after idle cycles", rdata, 32'h60);
        write_reg(A_PEND, 32'h60);
        read_reg(A_SRC, v);  check("R5 R6 both cleared", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_levels();
        t_rsp();
        t_ibi();
        t_addr();
        t_set_wins();
        t_mask_sel();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule